// File: doc/BRIEF.md
# Flash write-protection controller

This block is the command-gating and protection core of a 512 KB serial NOR flash. A frame decoder hands it one opcode per completed command frame, with a target byte address and, for a status write, one data byte. The block keeps the write-enable latch, a five-bit protect-range code, a complement bit, two status-lock bits and a deep power-down flag. For every modifying command it returns a one-cycle response with an accept or reject decision. On acceptance it also pulses an execute strobe that the array sequencer acts on.

The protected region is decoded from the range code. The code selects the whole array, nothing, an upper or lower half, quarter or eighth, or a 4 KB to 32 KB window at the top or bottom of the array. The complement bit inverts the selected region. The active-low write-protect pin freezes the range code and the lock bits. The power-down flag makes the block deaf to everything but the wake command.

Top module: `flash_guard`

## Requirements
- R1: Opcode 06h sets the write-enable latch. A modify command (01h status write, 02h page program, 20h sector erase, D8h block erase, C7h chip erase, 44h security erase, 42h security program) that arrives with the latch clear is rejected. It gives rsp_valid=1, rsp_accept=0 and no exec_stb, and the status bits stay unchanged.
- R2: The latch is clear after reset and after opcode 04h. It is also clear after every modify command, whether that command was accepted or rejected.
- R3: An accepted status write loads cmd_data[4:0] into the range code, cmd_data[5] into the complement bit and cmd_data[7:6] into the lock bits. While wp_n is low, the range code and the lock bits keep their values, and the complement bit is still written.
- R4: Opcode B9h sets stat_pd. While stat_pd is set, every opcode other than ABh changes no state and gives no response. ABh clears stat_pd.
- R5: With the complement bit 0, a range code whose low three bits are 000 protects nothing. Codes 0x1xx and 1x111 protect 0x00000 to 0x7FFFF.
- R6: With the complement bit 0 and code bits [4:3]=00, low bits 001, 010 and 011 protect the top 64 KB, 128 KB and 256 KB. With bits [4:3]=01, the same low bits protect the bottom 64 KB, 128 KB and 256 KB.
- R7: With the complement bit 0 and code bits [4:3]=10, low bits 001, 010 and 011 protect the top 4 KB, 8 KB and 16 KB, and 100, 101 and 110 protect the top 32 KB. With bits [4:3]=11, the same low bits protect the same sizes at the bottom.
- R8: With the complement bit 1, the protected set is exactly the addresses that the code leaves unprotected with the complement bit 0.
- R9: A page program, sector erase or block erase to a protected address is rejected. A chip erase is rejected if any address is protected. Security-register commands are not range checked.
- R10: A command sampled with cmd_valid at one rising edge produces its rsp_valid, rsp_accept, exec_stb and status update at that same edge. The pulses last one cycle.
- R11: After reset all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cmd_valid | input | 1 | One-cycle pulse: a command frame has completed |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W (19) | Target byte address |
| cmd_data | input | 8 | Status write data: [4:0] range code, [5] complement, [7:6] lock |
| wp_n | input | 1 | Active-low write-protect pin |
| rsp_valid | output | 1 | A modify command has been decided |
| rsp_accept | output | 1 | The decision was accept |
| exec_stb | output | 1 | Run the accepted command |
| stat_wel | output | 1 | Write-enable latch |
| stat_bp | output | 5 | Protect-range code |
| stat_cmp | output | 1 | Complement bit |
| stat_srp | output | 2 | Status-lock bits |
| stat_pd | output | 1 | Deep power-down flag |

## Verification
The bench sweeps all 32 range codes under both complement values. It programs addresses one byte on either side of every window edge, at both ends of the array. A decoder with an off-by-one edge, a swapped top and bottom, or a wrong alias for the 10x and 110 codes would accept a write it should refuse. Chip erase is tested against each code, which catches a decoder that treats complement-of-everything as still protected. Rejected commands are checked to clear the latch, the pin is checked to freeze only the range and lock bits, and power-down is checked to swallow write-disable and status writes. A design that clears the latch only on success, freezes the complement bit, or lets one command through while asleep would show a wrong status bit.

// File: rtl/fg_pkg.sv
package fg_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_PP     = 8'h02;
  localparam logic [7:0] OP_SE     = 8'h20;
  localparam logic [7:0] OP_BE     = 8'hD8;
  localparam logic [7:0] OP_CE     = 8'hC7;
  localparam logic [7:0] OP_SEC_ER = 8'h44;
  localparam logic [7:0] OP_SEC_PG = 8'h42;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [3:0] {
    K_NONE,
    K_ENABLE,
    K_DISABLE,
    K_STATUS,
    K_RANGED,
    K_WHOLE,
    K_SECREG,
    K_SLEEP,
    K_WAKE
  } fg_kind_e;

  typedef struct packed {
    logic [1:0] srp;
    logic       cmp;
    logic [4:0] bp;
  } fg_stat_t;

endpackage

// File: rtl/fg_decode.sv
module fg_decode
  import fg_pkg::*;
(
  input  logic [7:0] op,
  output fg_kind_e   kind
);

  always_comb begin
    case (op)
      OP_WREN:              kind = K_ENABLE;
      OP_WRDI:              kind = K_DISABLE;
      OP_WRSR:              kind = K_STATUS;
      OP_PP, OP_SE, OP_BE:  kind = K_RANGED;
      OP_CE:                kind = K_WHOLE;
      OP_SEC_ER, OP_SEC_PG: kind = K_SECREG;
      OP_SLEEP:             kind = K_SLEEP;
      OP_WAKE:              kind = K_WAKE;
      default:              kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/fg_range.sv
module fg_range #(
  parameter int ADDR_W = 19,
  parameter int SEC_W  = 12
) (
  input  logic [4:0]        bp,
  input  logic              cmp,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_hit,
  output logic              any_prot
);

  localparam int LOGW        = $clog2(ADDR_W + 1);
  localparam int EIGHTH_LOG  = ADDR_W - 3;
  localparam int SMALL_MAX   = SEC_W + 3;
  localparam logic [ADDR_W:0] TOTAL = {1'b1, {ADDR_W{1'b0}}};

  logic            empty, full, at_top;
  logic [LOGW-1:0] size_log;
  logic [ADDR_W:0] size, addr_ext;
  logic            in_low, in_high, raw_hit;

  // code to region: empty, whole, or a power-of-two window at one end
  always_comb begin
    empty    = 1'b0;
    full     = 1'b0;
    at_top   = ~bp[3];
    size_log = LOGW'(SEC_W);
    if (bp[2:0] == 3'b000) begin
      empty = 1'b1;
    end else if (!bp[4]) begin
      if (bp[2]) full = 1'b1;
      else       size_log = LOGW'(EIGHTH_LOG) + LOGW'(bp[1:0]) - LOGW'(1);
    end else begin
      if (bp[2:0] == 3'b111) full = 1'b1;
      else if (bp[2])        size_log = LOGW'(SMALL_MAX);
      else                   size_log = LOGW'(SEC_W) + LOGW'(bp[1:0]) - LOGW'(1);
    end
  end

  always_comb begin
    size     = {{ADDR_W{1'b0}}, 1'b1} << size_log;
    addr_ext = {1'b0, addr};
    in_low   = addr_ext < size;
    in_high  = addr_ext >= (TOTAL - size);
    raw_hit  = full | (~empty & (at_top ? in_high : in_low));
    addr_hit = raw_hit ^ cmp;
    any_prot = cmp ? ~full : ~empty;
  end

endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  fg_kind_e kind,
  input  fg_stat_t wr_data,
  input  logic     wp_n,
  input  logic     addr_hit,
  input  logic     any_prot,
  output logic     wel,
  output fg_stat_t stat,
  output logic     pd,
  output logic     rsp_valid,
  output logic     rsp_accept,
  output logic     exec_stb
);

  logic     wel_q, wel_d;
  fg_stat_t stat_q, stat_d;
  logic     pd_q, pd_d;
  logic     rv_q, rv_d, ra_q, ra_d, ex_q, ex_d;
  logic     blocked;

  always_comb begin
    wel_d   = wel_q;
    stat_d  = stat_q;
    pd_d    = pd_q;
    rv_d    = 1'b0;
    ra_d    = 1'b0;
    ex_d    = 1'b0;
    blocked = ((kind == K_RANGED) && addr_hit) || ((kind == K_WHOLE) && any_prot);
    if (cmd_valid) begin
      if (pd_q) begin
        if (kind == K_WAKE) pd_d = 1'b0;
      end else begin
        case (kind)
          K_ENABLE:  wel_d = 1'b1;
          K_DISABLE: wel_d = 1'b0;
          K_SLEEP:   pd_d  = 1'b1;
          K_STATUS, K_RANGED, K_WHOLE, K_SECREG: begin
            rv_d  = 1'b1;
            wel_d = 1'b0;
            if (wel_q && !blocked) begin
              ra_d = 1'b1;
              ex_d = 1'b1;
              if (kind == K_STATUS) begin
                stat_d.cmp = wr_data.cmp;
                if (wp_n) begin
                  stat_d.bp  = wr_data.bp;
                  stat_d.srp = wr_data.srp;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      stat_q <= '0;
      pd_q   <= 1'b0;
      rv_q   <= 1'b0;
      ra_q   <= 1'b0;
      ex_q   <= 1'b0;
    end else begin
      if (cmd_valid) begin
        wel_q  <= wel_d;
        stat_q <= stat_d;
        pd_q   <= pd_d;
      end
      rv_q <= rv_d;
      ra_q <= ra_d;
      ex_q <= ex_d;
    end
  end

  assign wel        = wel_q;
  assign stat       = stat_q;
  assign pd         = pd_q;
  assign rsp_valid  = rv_q;
  assign rsp_accept = ra_q;
  assign exec_stb   = ex_q;

  // R1
  exec_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> $past(wel_q));

  // R2
  wel_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !wel_q);

  // R3
  wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wp_n) |-> ($stable(stat_q.bp) && $stable(stat_q.srp)));

  // R4
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_q) && !($past(cmd_valid) && $past(kind) == K_WAKE))
      |-> (pd_q && !rsp_valid && $stable(stat_q) && $stable(wel_q)));

  // R10
  exec_is_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> (rsp_valid && rsp_accept));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SEC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic              exec_stb,
  output logic              stat_wel,
  output logic [4:0]        stat_bp,
  output logic              stat_cmp,
  output logic [1:0]        stat_srp,
  output logic              stat_pd
);

  fg_kind_e kind;
  fg_stat_t stat;
  logic     addr_hit, any_prot;

  fg_decode u_decode (
    .op   (cmd_op),
    .kind (kind)
  );

  fg_range #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_range (
    .bp       (stat.bp),
    .cmp      (stat.cmp),
    .addr     (cmd_addr),
    .addr_hit (addr_hit),
    .any_prot (any_prot)
  );

  fg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .kind       (kind),
    .wr_data    (fg_stat_t'(cmd_data)),
    .wp_n       (wp_n),
    .addr_hit   (addr_hit),
    .any_prot   (any_prot),
    .wel        (stat_wel),
    .stat       (stat),
    .pd         (stat_pd),
    .rsp_valid  (rsp_valid),
    .rsp_accept (rsp_accept),
    .exec_stb   (exec_stb)
  );

  assign stat_bp  = stat.bp;
  assign stat_cmp = stat.cmp;
  assign stat_srp = stat.srp;

endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        wp_n;
  logic        rsp_valid, rsp_accept, exec_stb;
  logic        stat_wel, stat_cmp, stat_pd;
  logic [4:0]  stat_bp;
  logic [1:0]  stat_srp;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [18:0] edges [32];
  int n_edges;

  always #5 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .exec_stb(exec_stb),
    .stat_wel(stat_wel), .stat_bp(stat_bp), .stat_cmp(stat_cmp),
    .stat_srp(stat_srp), .stat_pd(stat_pd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkv(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one command frame; outputs are sampled at the following falling edge
  task automatic send(input logic [7:0] op, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_status(input logic [7:0] d);
    send(8'h06, '0, '0);
    send(8'h01, '0, d);
  endtask

  task automatic ref_range(input logic [4:0] bp, output bit empty, output bit full,
                           output int lo, output int hi);
    empty = 0; full = 0; lo = 0; hi = 0;
    casez (bp)
      5'b??000: empty = 1;
      5'b0?1??, 5'b1?111: full = 1;
      5'b00001: begin lo = 'h70000; hi = 'h7FFFF; end
      5'b00010: begin lo = 'h60000; hi = 'h7FFFF; end
      5'b00011: begin lo = 'h40000; hi = 'h7FFFF; end
      5'b01001: begin lo = 0; hi = 'h0FFFF; end
      5'b01010: begin lo = 0; hi = 'h1FFFF; end
      5'b01011: begin lo = 0; hi = 'h3FFFF; end
      5'b10001: begin lo = 'h7F000; hi = 'h7FFFF; end
      5'b10010: begin lo = 'h7E000; hi = 'h7FFFF; end
      5'b10011: begin lo = 'h7C000; hi = 'h7FFFF; end
      5'b10100, 5'b10101, 5'b10110: begin lo = 'h78000; hi = 'h7FFFF; end
      5'b11001: begin lo = 0; hi = 'h00FFF; end
      5'b11010: begin lo = 0; hi = 'h01FFF; end
      5'b11011: begin lo = 0; hi = 'h03FFF; end
      default:  begin lo = 0; hi = 'h07FFF; end
    endcase
  endtask

  task automatic t_reset;
    chkv("R11 wel", stat_wel, 0);
    chkv("R11 bp", stat_bp, 0);
    chkv("R11 cmp", stat_cmp, 0);
    chkv("R11 srp", stat_srp, 0);
    chkv("R11 pd", stat_pd, 0);
    chkv("R11 rsp", rsp_valid, 0);
  endtask

  task automatic t_latch;
    send(8'h06, '0, '0);
    chkv("R1 wren sets", stat_wel, 1);
    chkv("R10 no rsp for wren", rsp_valid, 0);
    send(8'h04, '0, '0);
    chkv("R2 wrdi clears", stat_wel, 0);
    send(8'h02, 19'h100, '0);
    chkv("R1 rsp without latch", rsp_valid, 1);
    chkv("R1 reject without latch", rsp_accept, 0);
    chkv("R1 no exec without latch", exec_stb, 0);
    send(8'h01, '0, 8'hDF);
    chkv("R1 status unchanged bp", stat_bp, 0);
    chkv("R1 status unchanged srp", stat_srp, 0);
    foreach (edges[i]) begin end
    for (int k = 0; k < 7; k++) begin
      logic [7:0] op;
      case (k)
        0: op = 8'h02; 1: op = 8'h20; 2: op = 8'hD8; 3: op = 8'hC7;
        4: op = 8'h44; 5: op = 8'h42; default: op = 8'h01;
      endcase
      send(8'h06, '0, '0);
      send(op, 19'h1234, 8'h00);
      chkv("R10 rsp pulse", rsp_valid, 1);
      chkv("R1 accepted with latch", rsp_accept, 1);
      chkv("R10 exec pulse", exec_stb, 1);
      chkv("R2 latch clear after modify", stat_wel, 0);
      @(negedge clk);
      chkv("R10 rsp one cycle", rsp_valid, 0);
      chkv("R10 exec one cycle", exec_stb, 0);
    end
    reset_pulse();
    chkv("R2 reset clears latch", stat_wel, 0);
  endtask

  task automatic reset_pulse;
    send(8'h06, '0, '0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_wp;
    set_status(8'h00);
    wp_n = 1'b0;
    set_status(8'hE5);
    chkv("R3 accepted under wp", rsp_accept, 1);
    chkv("R3 bp frozen", stat_bp, 0);
    chkv("R3 srp frozen", stat_srp, 0);
    chkv("R3 cmp written", stat_cmp, 1);
    wp_n = 1'b1;
    set_status(8'hC3);
    chkv("R3 bp written", stat_bp, 3);
    chkv("R3 srp written", stat_srp, 3);
    chkv("R3 cmp cleared", stat_cmp, 0);
    set_status(8'h00);
  endtask

  task automatic t_sleep;
    set_status(8'h00);
    send(8'h06, '0, '0);
    send(8'hB9, '0, '0);
    chkv("R4 enter pd", stat_pd, 1);
    send(8'h04, '0, '0);
    chkv("R4 wrdi ignored", stat_wel, 1);
    send(8'h01, '0, 8'h1F);
    chkv("R4 status write no rsp", rsp_valid, 0);
    chkv("R4 status write ignored", stat_bp, 0);
    send(8'h02, 19'h10, '0);
    chkv("R4 program no rsp", rsp_valid, 0);
    chkv("R4 latch kept", stat_wel, 1);
    send(8'hAB, '0, '0);
    chkv("R4 wake", stat_pd, 0);
    send(8'h02, 19'h10, '0);
    chkv("R4 program after wake", rsp_accept, 1);
  endtask

  task automatic t_ops;
    set_status(8'h01);
    send(8'h06, '0, '0);
    send(8'h20, 19'h70000, '0);
    chkv("R9 sector erase protected", rsp_accept, 0);
    chkv("R2 latch clear after reject", stat_wel, 0);
    send(8'h06, '0, '0);
    send(8'hD8, 19'h6FFFF, '0);
    chkv("R9 block erase free", rsp_accept, 1);
    set_status(8'h1C);
    send(8'h06, '0, '0);
    send(8'h44, '0, '0);
    chkv("R9 security erase not range checked", rsp_accept, 1);
    set_status(8'h00);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 2; c++) begin
      for (int code = 0; code < 32; code++) begin
        bit e, f;
        int lo, hi;
        string rq;
        ref_range(code[4:0], e, f, lo, hi);
        rq = (c == 1) ? "R8" : (code[2:0] == 0 || f) ? "R5" : code[4] ? "R7" : "R6";
        set_status({2'b00, c[0], code[4:0]});
        chkv("R3 code loaded", stat_bp, code);
        for (int i = 0; i < n_edges; i++) begin
          bit prot;
          prot = (f || (!e && int'(edges[i]) >= lo && int'(edges[i]) <= hi)) ^ c[0];
          send(8'h06, '0, '0);
          send(8'h02, edges[i], '0);
          chk(rsp_accept == !prot, $sformatf("%s code=%0h cmp=%0d addr=%0h", rq, code, c, edges[i]),
              rsp_accept, !prot);
        end
        send(8'h06, '0, '0);
        send(8'hC7, '0, '0);
        chkv($sformatf("R9 chip erase code=%0h cmp=%0d", code, c), rsp_accept,
             (c == 1) ? f : e);
      end
    end
    set_status(8'h00);
  endtask

  initial begin
    int w = 0;
    while (!done) begin
      @(posedge clk);
      w++;
      if (w > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", w);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    n_edges = 0;
    edges[n_edges++] = 19'h00000;
    edges[n_edges++] = 19'h7FFFF;
    for (int k = 0; k < 7; k++) begin
      int s;
      s = (k < 4) ? ('h1000 << k) : ('h10000 << (k - 4));
      edges[n_edges++] = 19'(s - 1);
      edges[n_edges++] = 19'(s);
      edges[n_edges++] = 19'('h80000 - s - 1);
      edges[n_edges++] = 19'('h80000 - s);
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_wp();
    t_sleep();
    t_ops();
    t_sweep();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule